// File: doc/BRIEF.md
# Cache Line Burst Address Sequencer

This block produces the word address for every data phase of a memory burst. At the start of a burst it captures a starting word address, a programmable cache line size in words and an ordering mode. Each accepted data phase then moves the address forward by one step. In linear mode the address simply counts upward. In wrap mode the address counts upward inside the current cache line and returns to the start of that line at its end. In toggle mode each in-line offset is the starting offset XORed with a counter. Both line-based modes give the critical word first. Once a whole line has been issued, they continue into the next line at the same starting offset.

The block also judges whether it can serve the request. The supported line sizes are the powers of two from 4 to 32 words, and the mode code 01 is reserved. If the line size or the mode is not supported, a flag tells the bus side to end the burst after the first word. In that case the burst closes on the next accepted phase. Handshaking and data movement are handled outside this block.

Top module: `cl_burst_seq`

## Requirements
- R1: After a synchronous reset, `addr` is 0, `active` is 0 and `single_word` is 0.
- R2: A cycle with `start` high loads `addr` with `start_addr` and sets `active` on the next clock. `start` takes priority over `advance`, and a `start` during a burst restarts it.
- R3: In linear mode (`order` = 00), each accepted `advance` adds 1 to `addr`, and this continues across cache line boundaries.
- R4: In wrap mode (`order` = 11), the in-line offset counts up from the starting offset and wraps to offset 0 after the last word of the line.
- R5: In toggle mode (`order` = 10), the k-th word inside a line has offset (starting offset XOR k), for k from 0 to line size minus 1.
- R6: In wrap and toggle modes, the word after the last word of a line lies in the next line (line base plus line size) and starts again at the original starting offset.
- R7: With a starting offset of 0 within the line, linear, wrap and toggle produce identical address sequences.
- R8: A `line_words` value that is not 4, 8, 16 or 32 (including 0) sets `single_word` on the cycle after `start`. The first `advance` then clears `active` and leaves `addr` unchanged.
- R9: The reserved mode `order` = 01 is unsupported. It sets `single_word` on the cycle after `start`, and the burst then ends after the first word, as in R8.
- R10: `advance` has no effect while `active` is 0. While `active` is 1 and neither `advance` nor `start` is high, `addr` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new burst using the inputs below |
| start_addr | input | AW | Word address of the first data phase |
| order | input | 2 | Ordering mode: 00 linear, 10 toggle, 11 wrap, 01 reserved |
| line_words | input | LW | Cache line size in words |
| advance | input | 1 | A data phase was accepted this cycle |
| addr | output | AW | Word address of the current data phase (registered) |
| active | output | 1 | A burst is in progress |
| single_word | output | 1 | The request is unsupported and the burst must stop after the first word |

## Verification
The bench builds the block with its default parameters: a 16-bit address, an 8-bit size register, and line sizes from 4 to 32 words. This lets the bench drive the largest line, with toggle counts up to 31 and line-base carries into the upper address bits. It can also drive size values that are out of range on both sides, such as 2 and 64. Non-powers-of-two and zero are covered too. The sequences run long enough to cross at least one line boundary in every mode. Nonzero starting offsets separate wrap order from toggle order.

// File: rtl/clbs_pkg.sv
`timescale 1ns/1ps
package clbs_pkg;
  // Ordering codes; the code values are part of the external contract.
  typedef enum logic [1:0] {
    ORD_LINEAR = 2'b00,
    ORD_RSVD   = 2'b01,
    ORD_TOGGLE = 2'b10,
    ORD_WRAP   = 2'b11
  } order_e;
endpackage

// File: rtl/clbs_size_decode.sv
`timescale 1ns/1ps
// Recognises power-of-two line sizes in [2**MIN_LOG2, 2**MAX_LOG2].
module clbs_size_decode #(
  parameter int LW       = 8,
  parameter int MIN_LOG2 = 2,
  parameter int MAX_LOG2 = 5
) (
  input  logic [LW-1:0]       line_words,
  output logic                size_ok,
  output logic [MAX_LOG2-1:0] size_mask
);
  localparam int NSZ = MAX_LOG2 - MIN_LOG2 + 1;

  logic [NSZ-1:0]      hit;
  logic [MAX_LOG2-1:0] mask_part [NSZ];

  for (genvar g = 0; g < NSZ; g++) begin : g_size
    localparam int K = MIN_LOG2 + g;
    assign hit[g]       = (line_words == (LW'(1) << K));
    assign mask_part[g] = hit[g] ? MAX_LOG2'((1 << K) - 1) : '0;
  end

  always_comb begin
    size_mask = '0;
    for (int i = 0; i < NSZ; i++) size_mask |= mask_part[i];
  end

  assign size_ok = |hit;
endmodule

// File: rtl/clbs_next_addr.sv
`timescale 1ns/1ps
// Combinational next-address step for all ordering modes.
module clbs_next_addr
  import clbs_pkg::*;
#(
  parameter int AW = 16,
  parameter int MW = 5
) (
  input  order_e        order,
  input  logic [AW-1:0] cur_addr,
  input  logic [AW-1:0] base,
  input  logic [MW-1:0] off,
  input  logic [MW-1:0] cnt,
  input  logic [MW-1:0] mask,
  output logic [AW-1:0] nxt_addr,
  output logic [AW-1:0] nxt_base,
  output logic [MW-1:0] nxt_cnt
);
  logic          line_done;
  logic [AW-1:0] span;
  logic [MW-1:0] line_off;

  assign line_done = (cnt == mask);
  assign span      = AW'(mask) + AW'(1);
  assign nxt_cnt   = line_done ? '0 : MW'(cnt + MW'(1));
  assign nxt_base  = line_done ? base + span : base;

  always_comb begin
    case (order)
      ORD_WRAP: line_off = MW'(off + nxt_cnt) & mask;
      default:  line_off = (off ^ nxt_cnt) & mask;
    endcase
  end

  assign nxt_addr = (order == ORD_LINEAR) ? cur_addr + AW'(1)
                                          : nxt_base | AW'(line_off);
endmodule

// File: rtl/cl_burst_seq.sv
`timescale 1ns/1ps
module cl_burst_seq
  import clbs_pkg::*;
#(
  parameter int AW       = 16,
  parameter int LW       = 8,
  parameter int MIN_LOG2 = 2,
  parameter int MAX_LOG2 = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [1:0]    order,
  input  logic [LW-1:0] line_words,
  input  logic          advance,
  output logic [AW-1:0] addr,
  output logic          active,
  output logic          single_word
);
  localparam int MW = MAX_LOG2;

  logic          size_ok;
  logic [MW-1:0] size_mask;
  logic          order_ok;

  order_e        mode_q;
  logic [AW-1:0] addr_q, base_q;
  logic [MW-1:0] off_q, cnt_q, mask_q;
  logic          active_q, single_q;

  logic [AW-1:0] nxt_addr, nxt_base;
  logic [MW-1:0] nxt_cnt;

  clbs_size_decode #(.LW(LW), .MIN_LOG2(MIN_LOG2), .MAX_LOG2(MAX_LOG2)) u_size (
    .line_words (line_words),
    .size_ok    (size_ok),
    .size_mask  (size_mask)
  );

  assign order_ok = (order != ORD_RSVD);

  clbs_next_addr #(.AW(AW), .MW(MW)) u_next (
    .order    (mode_q),
    .cur_addr (addr_q),
    .base     (base_q),
    .off      (off_q),
    .cnt      (cnt_q),
    .mask     (mask_q),
    .nxt_addr (nxt_addr),
    .nxt_base (nxt_base),
    .nxt_cnt  (nxt_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= ORD_LINEAR;
      addr_q   <= '0;
      base_q   <= '0;
      off_q    <= '0;
      cnt_q    <= '0;
      mask_q   <= '0;
      active_q <= 1'b0;
      single_q <= 1'b0;
    end else if (start) begin
      mode_q   <= order_e'(order);
      addr_q   <= start_addr;
      base_q   <= start_addr & ~AW'(size_mask);
      off_q    <= start_addr[MW-1:0] & size_mask;
      cnt_q    <= '0;
      mask_q   <= size_mask;
      active_q <= 1'b1;
      single_q <= !(size_ok && order_ok);
    end else if (active_q && advance) begin
      if (single_q) begin
        active_q <= 1'b0;
      end else begin
        addr_q <= nxt_addr;
        base_q <= nxt_base;
        cnt_q  <= nxt_cnt;
      end
    end
  end

  assign addr        = addr_q;
  assign active      = active_q;
  assign single_word = single_q;
endmodule

// File: rtl/clbs_checker.sv
`timescale 1ns/1ps
module clbs_checker #(
  parameter int AW = 16,
  parameter int LW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [AW-1:0] start_addr,
  input logic [1:0]    order,
  input logic [LW-1:0] line_words,
  input logic          advance,
  input logic [AW-1:0] addr,
  input logic          active,
  input logic          single_word
);
  logic [1:0] ord_seen;
  always_ff @(posedge clk) begin
    if (rst)        ord_seen <= 2'b00;
    else if (start) ord_seen <= order;
  end

  p_reset_r1: assert property (@(posedge clk) rst |=> (!active && addr == '0 && !single_word));
  p_start_r2: assert property (@(posedge clk) disable iff (rst)
    start |=> (active && addr == $past(start_addr)));
  p_linear_r3: assert property (@(posedge clk) disable iff (rst)
    (active && advance && !start && !single_word && ord_seen == 2'b00) |=> addr == $past(addr) + AW'(1));
  p_zero_size_r8: assert property (@(posedge clk) disable iff (rst)
    (start && line_words == '0) |=> single_word);
  p_single_end_r8: assert property (@(posedge clk) disable iff (rst)
    (active && single_word && advance && !start) |=> (!active && $stable(addr)));
  p_rsvd_r9: assert property (@(posedge clk) disable iff (rst)
    (start && order == 2'b01) |=> single_word);
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (active && !advance && !start) |=> $stable(addr));
  p_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (!active && !start) |=> (!active && $stable(addr)));
endmodule

bind cl_burst_seq clbs_checker #(.AW(AW), .LW(LW)) u_clbs_checker (
  .clk(clk), .rst(rst), .start(start), .start_addr(start_addr), .order(order),
  .line_words(line_words), .advance(advance), .addr(addr), .active(active),
  .single_word(single_word)
);

// File: tb/cl_burst_seq_test.sv
`timescale 1ns/1ps
module cl_burst_seq_test;
  localparam int AW = 16;
  localparam int LW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [1:0]    order = 2'b00;
  logic [LW-1:0] line_words = '0;
  logic          advance = 1'b0;
  logic [AW-1:0] addr;
  logic          active;
  logic          single_word;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  cl_burst_seq uut (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr), .order(order),
    .line_words(line_words), .advance(advance), .addr(addr), .active(active),
    .single_word(single_word)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int model(input int sa, input int md, input int len, input int k);
    int off, base, ln, c;
    if (md == 0) return (sa + k) & 16'hFFFF;
    off  = sa % len;
    ln   = k / len;
    c    = k % len;
    base = sa - off + ln * len;
    if (md == 3) return (base + ((off + c) % len)) & 16'hFFFF;
    return (base + (off ^ c)) & 16'hFFFF;
  endfunction

  task automatic begin_burst(input int sa, input int md, input int len);
    @(negedge clk);
    start = 1'b1; start_addr = AW'(sa); order = 2'(md); line_words = LW'(len);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic step();
    advance = 1'b1;
    @(negedge clk);
    advance = 1'b0;
  endtask

  task automatic run_seq(input string req, input int sa, input int md, input int len, input int n);
    begin_burst(sa, md, len);
    check({req, " first"}, int'(addr), sa);
    check({req, " active"}, int'(active), 1);
    check({req, " supported"}, int'(single_word), 0);
    for (int k = 1; k < n; k++) begin
      step();
      check(req, int'(addr), model(sa, md, len, k));
    end
  endtask

  task automatic t_reset();
    check("R1 addr", int'(addr), 0);
    check("R1 active", int'(active), 0);
    check("R1 single", int'(single_word), 0);
  endtask

  task automatic t_linear();
    run_seq("R3 linear", 16'h0106, 0, 8, 12);
    run_seq("R3 linear carry", 16'h00FD, 0, 4, 6);
  endtask

  task automatic t_wrap();
    run_seq("R4 R6 wrap", 16'h0045, 3, 8, 20);
    run_seq("R4 R6 wrap top", 16'hFFF2, 3, 4, 10);
  endtask

  task automatic t_toggle();
    run_seq("R5 R6 toggle", 16'h0235, 2, 8, 20);
    run_seq("R5 R6 toggle 32", 16'h0013, 2, 32, 40);
    run_seq("R5 toggle 16", 16'h030B, 2, 16, 18);
  endtask

  task automatic t_zero_offset();
    int ref_seq [12];
    for (int md = 0; md < 4; md++) begin
      if (md == 1) continue;
      begin_burst(16'h0180, md, 16);
      for (int k = 0; k < 12; k++) begin
        if (md == 0) ref_seq[k] = int'(addr);
        else check("R7 same order", int'(addr), ref_seq[k]);
        check("R7 value", int'(addr), 16'h0180 + k);
        if (k < 11) step();
      end
    end
  endtask

  task automatic t_bad_size();
    int bad [5] = '{0, 6, 64, 2, 12};
    foreach (bad[i]) begin
      begin_burst(16'h0055, 3, bad[i]);
      check("R8 flag", int'(single_word), 1);
      check("R8 first addr", int'(addr), 16'h0055);
      step();
      check("R8 ends", int'(active), 0);
      check("R8 addr kept", int'(addr), 16'h0055);
    end
  endtask

  task automatic t_bad_mode();
    begin_burst(16'h0077, 1, 8);
    check("R9 flag", int'(single_word), 1);
    step();
    check("R9 ends", int'(active), 0);
    check("R9 addr kept", int'(addr), 16'h0077);
  endtask

  task automatic t_idle_hold();
    step();
    step();
    check("R10 idle active", int'(active), 0);
    check("R10 idle addr", int'(addr), 16'h0077);
    begin_burst(16'h0021, 2, 4);
    repeat (3) @(negedge clk);
    check("R10 hold", int'(addr), 16'h0021);
    step();
    check("R10 resume", int'(addr), 16'h0020);
  endtask

  task automatic t_restart();
    begin_burst(16'h0400, 0, 8);
    step();
    step();
    begin_burst(16'h0813, 3, 4);
    check("R2 restart addr", int'(addr), 16'h0813);
    check("R2 restart flag", int'(single_word), 0);
    step();
    check("R2 restart next", int'(addr), 16'h0810);
    @(negedge clk);
    start = 1'b1; advance = 1'b1; start_addr = 16'h0900; order = 2'b00; line_words = 8'd8;
    @(negedge clk);
    start = 1'b0; advance = 1'b0;
    check("R2 start priority", int'(addr), 16'h0900);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_linear();
    t_wrap();
    t_toggle();
    t_zero_offset();
    t_bad_size();
    t_bad_mode();
    t_idle_hold();
    t_restart();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule